// File: doc/BRIEF.md
# Network JTAG command decoder

This block sits between a TCP receive byte stream and a JTAG shift engine and implements the server side of the virtual-cable command set. Three commands are told apart by their ASCII prefixes. The first asks for the server version. The second sets the TCK period. The third shifts a vector pair into the scan chain. The period request and the bit count arrive as 4-byte little-endian integers. The TMS and TDI vectors that follow are byte-rounded.

A whole shift payload is stored in local byte RAMs before any scan activity starts. The shifter is then driven one byte per request, and the sampled TDO bytes are streamed back. The decoder handles one command at a time. It stops taking input from the end of a command until the last reply byte has been accepted.

A malformed prefix or an oversized bit count locks the decoder in an error state until reset. In that state it keeps draining its input. The TCK period in effect is clamped to a supported range. It is also presented as a half-period divider count for the clock generator.

Top module: `jtag_net_cmd_decoder`

## Requirements
- R1: A prefix byte that does not continue one of `getinfo:`, `settck:` or `shift:` sets `err`. `err` stays set until reset. In that state `in_ready` stays 1, every input byte is discarded, and no reply byte or shifter request appears.
- R2: `getinfo:` is answered with the ASCII bytes `xvcServer_v1.0:` followed by MAX_BITS in decimal and a line feed (0x0A), emitted in that order.
- R3: `settck:` is followed by a 4-byte period in ns, least significant byte first. The period is clamped to [MIN_NS, MAX_NS] and becomes the period in effect. The reply is that period as 4 bytes, least significant first.
- R4: `tck_div` equals the period in effect divided by 2*CLK_NS, rounded down. After reset the period in effect is DEF_NS.
- R5: `shift:` is followed by a 4-byte little-endian bit count n, then ceil(n/8) TMS bytes, then ceil(n/8) TDI bytes. No shifter request is raised before the last TDI byte is accepted. A count of 0 produces no request and no reply.
- R6: Byte k of the vectors goes to the shifter in ascending k, starting with byte 0. Each request carries the TMS byte and TDI byte (bit 0 goes first) and `sh_cnt`. `sh_cnt` is 8 for every byte except the last, which carries n mod 8 (8 when n is a multiple of 8). Request fields hold until `sh_ack`.
- R7: The reply to `shift:` is ceil(n/8) TDO bytes in ascending byte order. In the last byte, the bits at and above `sh_cnt` are 0 whatever the shifter returns.
- R8: A bit count larger than MAX_BITS sets `err`, with the same behaviour as R1.
- R9: `in_ready` is 0 while shifting and while a reply is pending. It returns to 1 only after the final reply byte is taken.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold.
- R11: After reset, `in_ready` is 1 and `out_valid`, `sh_req` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| out_valid | output | 1 | Reply byte offered |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Reply byte taken when high with out_valid |
| sh_req | output | 1 | Shift request for one byte |
| sh_tms | output | 8 | TMS bits, bit 0 first |
| sh_tdi | output | 8 | TDI bits, bit 0 first |
| sh_cnt | output | 4 | Valid bits in this request, 1 to 8 |
| sh_ack | input | 1 | One-cycle completion pulse from the shifter |
| sh_tdo | input | 8 | Sampled TDO bits, valid with sh_ack |
| tck_div | output | DIV_W | Half-period divider count for TCK |
| err | output | 1 | Sticky protocol error |

## Verification
The hardest case to reach is the partial last byte: it needs the shift-count remainder, the per-byte count sent to the shifter and the masking of TDO bits to agree. The shifter model also deliberately returns ones in every unused TDO bit. To cover it, every bit count from 1 up to MAX_BITS is shifted, with computed TMS/TDI patterns and uneven reply backpressure, so each remainder is met at every vector length. The clamp edges are reached by period requests below, at and above both limits.

// File: rtl/jcd_pkg.sv
package jcd_pkg;

   typedef enum logic [1:0] {CMD_NONE, CMD_INFO, CMD_TCK, CMD_SHIFT} jcd_cmd_e;
   typedef enum logic [2:0] {S_PFX, S_ARG, S_LOAD, S_SHIFT, S_RESP, S_ERR} jcd_state_e;

   localparam logic [63:0]  STR_INFO  = "getinfo:";
   localparam logic [55:0]  STR_TCK   = "settck:";
   localparam logic [47:0]  STR_SHIFT = "shift:";
   localparam logic [119:0] STR_HDR   = "xvcServer_v1.0:";
   localparam int           HDR_LEN   = 15;

   function automatic int cmd_len(jcd_cmd_e c);
      case (c)
         CMD_INFO:  return 8;
         CMD_TCK:   return 7;
         CMD_SHIFT: return 6;
         default:   return 1;
      endcase
   endfunction

   function automatic logic [7:0] cmd_char(jcd_cmd_e c, int j);
      case (c)
         CMD_INFO:  return STR_INFO[8*(7-j) +: 8];
         CMD_TCK:   return STR_TCK[8*(6-j) +: 8];
         CMD_SHIFT: return STR_SHIFT[8*(5-j) +: 8];
         default:   return 8'h00;
      endcase
   endfunction

   function automatic int num_digits(int v);
      int t = v;
      int n = 1;
      for (int k = 0; k < 10; k++) begin
         if (t >= 10) begin
            t = t / 10;
            n = n + 1;
         end
      end
      return n;
   endfunction

   function automatic logic [7:0] info_char(int maxb, int j);
      int nd = num_digits(maxb);
      int d  = maxb;
      if (j < HDR_LEN) return STR_HDR[8*(HDR_LEN-1-j) +: 8];
      if (j >= HDR_LEN + nd) return 8'h0A;
      for (int k = 0; k < 10; k++)
         if (k < nd - 1 - (j - HDR_LEN)) d = d / 10;
      return 8'(d % 10) + 8'h30;
   endfunction

endpackage

// File: rtl/jcd_prefix_match.sv
module jcd_prefix_match
   import jcd_pkg::*;
(
   input  jcd_cmd_e   cur,
   input  logic [2:0] idx,
   input  logic [7:0] ch,
   output jcd_cmd_e   nxt,
   output logic       ok,
   output logic       last
);
   always_comb begin
      nxt = cur;
      if (idx == 3'd0) begin
         if (ch == "g")      nxt = CMD_INFO;
         else if (ch == "s") nxt = CMD_TCK;
         else                nxt = CMD_NONE;
      end else if (cur == CMD_TCK && idx == 3'd1 && ch == "h") begin
         nxt = CMD_SHIFT;
      end
      ok   = (nxt != CMD_NONE) && (ch == cmd_char(nxt, int'(idx)));
      last = (int'(idx) == cmd_len(nxt) - 1);
   end
endmodule

// File: rtl/jcd_byte_ram.sv
module jcd_byte_ram #(
   parameter int DEPTH = 8,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk)
      if (we) mem[waddr] <= wdata;

   assign rdata = mem[raddr];
endmodule

// File: rtl/jcd_tck_map.sv
module jcd_tck_map #(
   parameter int CLK_NS = 10,
   parameter int MIN_NS = 20,
   parameter int MAX_NS = 10000,
   parameter int DIV_W  = 16
) (
   input  logic [31:0]      req_ns,
   input  logic [31:0]      cur_ns,
   output logic [31:0]      clamp_ns,
   output logic [DIV_W-1:0] div
);
   localparam int HALF = 2 * CLK_NS;

   assign clamp_ns = (req_ns < 32'(MIN_NS)) ? 32'(MIN_NS) :
                     (req_ns > 32'(MAX_NS)) ? 32'(MAX_NS) : req_ns;

   generate
      if ((HALF & (HALF - 1)) == 0) begin : g_shift
         assign div = DIV_W'(cur_ns >> $clog2(HALF));
      end else begin : g_divide
         assign div = DIV_W'(cur_ns / 32'(HALF));
      end
   endgenerate
endmodule

// File: rtl/jtag_net_cmd_decoder.sv
module jtag_net_cmd_decoder
   import jcd_pkg::*;
#(
   parameter int MAX_BITS = 64,
   parameter int CLK_NS   = 10,
   parameter int MIN_NS   = 20,
   parameter int MAX_NS   = 10000,
   parameter int DEF_NS   = 1000,
   parameter int DIV_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready,
   output logic             sh_req,
   output logic [7:0]       sh_tms,
   output logic [7:0]       sh_tdi,
   output logic [3:0]       sh_cnt,
   input  logic             sh_ack,
   input  logic [7:0]       sh_tdo,
   output logic [DIV_W-1:0] tck_div,
   output logic             err
);
   localparam int NB       = (MAX_BITS + 7) / 8;
   localparam int AW       = (NB > 1) ? $clog2(NB) : 1;
   localparam int BW       = $clog2(MAX_BITS + 1);
   localparam int NBW      = $clog2(NB + 1);
   localparam int LW       = $clog2(2 * NB + 1);
   localparam int INFO_LEN = HDR_LEN + num_digits(MAX_BITS) + 1;
   localparam int RL_A     = (INFO_LEN > NB) ? INFO_LEN : NB;
   localparam int RL_MAX   = (RL_A > 4) ? RL_A : 4;
   localparam int RW       = $clog2(RL_MAX + 1);

   generate
      if (MAX_BITS < 8) begin : g_bad_bits
         $error("MAX_BITS must be at least 8");
      end
      if (MIN_NS < 2 * CLK_NS || MIN_NS > DEF_NS || DEF_NS > MAX_NS) begin : g_bad_ns
         $error("period limits must satisfy 2*CLK_NS <= MIN_NS <= DEF_NS <= MAX_NS");
      end
      if ((MAX_NS / (2 * CLK_NS)) >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_W too narrow for MAX_NS");
      end
   endgenerate

   jcd_state_e      st;
   jcd_cmd_e        cmd, m_cmd;
   logic [2:0]      pidx;
   logic [1:0]      acnt;
   logic [23:0]     arg;
   logic [31:0]     arg_full, period, clamp_ns, nb_full;
   logic [BW-1:0]   nbits;
   logic [NBW-1:0]  nbyt, sidx;
   logic [LW-1:0]   lidx;
   logic [RW-1:0]   ridx, rlen;
   logic            m_ok, m_last, in_fire, out_fire, last_byte;
   logic [7:0]      tms_rd, tdi_rd, tdo_rd, tdo_mask;

   assign arg_full  = {in_data, arg};
   assign nb_full   = (arg_full + 32'd7) >> 3;
   assign in_ready  = (st == S_PFX) || (st == S_ARG) || (st == S_LOAD) || (st == S_ERR);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = (st == S_RESP);
   assign out_fire  = out_valid && out_ready;
   assign sh_req    = (st == S_SHIFT);
   assign err       = (st == S_ERR);
   assign last_byte = (sidx == nbyt - NBW'(1));
   assign sh_cnt    = (last_byte && nbits[2:0] != 3'd0) ? {1'b0, nbits[2:0]} : 4'd8;
   assign tdo_mask  = 8'hFF >> (4'd8 - sh_cnt);
   assign sh_tms    = tms_rd;
   assign sh_tdi    = tdi_rd;

   jcd_prefix_match u_pfx (
      .cur(cmd), .idx(pidx), .ch(in_data), .nxt(m_cmd), .ok(m_ok), .last(m_last)
   );

   jcd_tck_map #(.CLK_NS(CLK_NS), .MIN_NS(MIN_NS), .MAX_NS(MAX_NS), .DIV_W(DIV_W)) u_tck (
      .req_ns(arg_full), .cur_ns(period), .clamp_ns(clamp_ns), .div(tck_div)
   );

   jcd_byte_ram #(.DEPTH(NB), .AW(AW)) u_tms (
      .clk(clk), .we(in_fire && st == S_LOAD && lidx < LW'(nbyt)),
      .waddr(AW'(lidx)), .wdata(in_data), .raddr(AW'(sidx)), .rdata(tms_rd)
   );

   jcd_byte_ram #(.DEPTH(NB), .AW(AW)) u_tdi (
      .clk(clk), .we(in_fire && st == S_LOAD && lidx >= LW'(nbyt)),
      .waddr(AW'(lidx - LW'(nbyt))), .wdata(in_data), .raddr(AW'(sidx)), .rdata(tdi_rd)
   );

   jcd_byte_ram #(.DEPTH(NB), .AW(AW)) u_tdo (
      .clk(clk), .we(sh_req && sh_ack),
      .waddr(AW'(sidx)), .wdata(sh_tdo & tdo_mask), .raddr(AW'(ridx)), .rdata(tdo_rd)
   );

   always_comb begin
      case (cmd)
         CMD_INFO: out_data = info_char(MAX_BITS, int'(ridx));
         CMD_TCK:  out_data = period[8*ridx[1:0] +: 8];
         default:  out_data = tdo_rd;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_PFX;
         cmd    <= CMD_NONE;
         pidx   <= '0;
         acnt   <= '0;
         arg    <= '0;
         period <= 32'(DEF_NS);
         nbits  <= '0;
         nbyt   <= '0;
         lidx   <= '0;
         sidx   <= '0;
         ridx   <= '0;
         rlen   <= '0;
      end else begin
         case (st)
            S_PFX: if (in_fire) begin
               if (!m_ok) begin
                  st <= S_ERR;
               end else begin
                  cmd <= m_cmd;
                  if (m_last) begin
                     pidx <= '0;
                     ridx <= '0;
                     acnt <= '0;
                     if (m_cmd == CMD_INFO) begin
                        st   <= S_RESP;
                        rlen <= RW'(INFO_LEN);
                     end else begin
                        st <= S_ARG;
                     end
                  end else begin
                     pidx <= pidx + 3'd1;
                  end
               end
            end
            S_ARG: if (in_fire) begin
               if (acnt != 2'd3) begin
                  arg[8*acnt +: 8] <= in_data;
                  acnt <= acnt + 2'd1;
               end else if (cmd == CMD_TCK) begin
                  period <= clamp_ns;
                  rlen   <= RW'(4);
                  st     <= S_RESP;
               end else if (arg_full > 32'(MAX_BITS)) begin
                  st <= S_ERR;
               end else if (arg_full == 32'd0) begin
                  st <= S_PFX;
               end else begin
                  nbits <= BW'(arg_full);
                  nbyt  <= NBW'(nb_full);
                  lidx  <= '0;
                  st    <= S_LOAD;
               end
            end
            S_LOAD: if (in_fire) begin
               if (lidx == LW'(2 * nbyt) - LW'(1)) begin
                  sidx <= '0;
                  st   <= S_SHIFT;
               end else begin
                  lidx <= lidx + LW'(1);
               end
            end
            S_SHIFT: if (sh_ack) begin
               if (last_byte) begin
                  rlen <= RW'(nbyt);
                  ridx <= '0;
                  st   <= S_RESP;
               end else begin
                  sidx <= sidx + NBW'(1);
               end
            end
            S_RESP: if (out_fire) begin
               if (ridx == rlen - RW'(1)) st <= S_PFX;
               else                       ridx <= ridx + RW'(1);
            end
            default: st <= S_ERR;
         endcase
      end
   end
endmodule

// File: rtl/jcd_checker.sv
module jcd_checker #(
   parameter int DIV_W  = 16,
   parameter int DIV_LO = 1,
   parameter int DIV_HI = 500
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             out_valid,
   input logic [7:0]       out_data,
   input logic             out_ready,
   input logic             sh_req,
   input logic [7:0]       sh_tms,
   input logic [7:0]       sh_tdi,
   input logic [3:0]       sh_cnt,
   input logic             sh_ack,
   input logic [DIV_W-1:0] tck_div,
   input logic             err
);
   p_reply_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_one_at_a_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_shift_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req |-> !in_ready && !out_valid);

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req && !sh_ack |=> sh_req && $stable(sh_tms) && $stable(sh_tdi) && $stable(sh_cnt));

   p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req |-> (sh_cnt >= 4'd1) && (sh_cnt <= 4'd8));

   p_err_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> in_ready && !out_valid && !sh_req);

   p_div_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tck_div >= DIV_W'(DIV_LO)) && (tck_div <= DIV_W'(DIV_HI)));
endmodule

bind jtag_net_cmd_decoder jcd_checker #(
   .DIV_W(DIV_W), .DIV_LO(MIN_NS / (2 * CLK_NS)), .DIV_HI(MAX_NS / (2 * CLK_NS))
) u_chk (.*);

// File: tb/tb_jtag_net_cmd_decoder.sv
module tb_jtag_net_cmd_decoder;
   localparam int MAXB   = 64;
   localparam int CLK_NS = 10;
   localparam int MIN_NS = 20;
   localparam int MAX_NS = 10000;
   localparam int DEF_NS = 1000;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, out_ready = 0, sh_ack = 0;
   logic [7:0] in_data = 0, sh_tdo = 0;
   logic in_ready, out_valid, sh_req, err;
   logic [7:0] out_data, sh_tms, sh_tdi;
   logic [3:0] sh_cnt;
   logic [15:0] tck_div;

   int n_cmp = 0, n_bad = 0, log_n = 0;
   logic [7:0] log_tms [64];
   logic [7:0] log_tdi [64];
   logic [3:0] log_cnt [64];
   bit done = 0;

   always #5 clk = ~clk;

   jtag_net_cmd_decoder #(.MAX_BITS(MAXB), .CLK_NS(CLK_NS), .MIN_NS(MIN_NS),
                          .MAX_NS(MAX_NS), .DEF_NS(DEF_NS), .DIV_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .sh_req(sh_req), .sh_tms(sh_tms), .sh_tdi(sh_tdi), .sh_cnt(sh_cnt),
      .sh_ack(sh_ack), .sh_tdo(sh_tdo), .tck_div(tck_div), .err(err)
   );

   // Shifter model: TDO is the inverse of TDI on valid bits, ones above them.
   initial begin
      forever begin
         @(negedge clk);
         if (sh_req) begin
            if (log_n < 64) begin
               log_tms[log_n] = sh_tms;
               log_tdi[log_n] = sh_tdi;
               log_cnt[log_n] = sh_cnt;
            end
            log_n++;
            repeat (2) @(negedge clk);
            sh_tdo = ~(sh_tdi & (8'hFF >> (4'd8 - sh_cnt)));
            sh_ack = 1;
            @(negedge clk);
            sh_ack = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      bit acc = 0;
      in_valid = 1;
      in_data  = b;
      while (!acc) begin
         acc = in_ready;
         @(negedge clk);
      end
      in_valid = 0;
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send_byte(s[i]);
   endtask

   task automatic send_u32(input int v);
      for (int i = 0; i < 4; i++) send_byte(8'(v >> (8 * i)));
   endtask

   task automatic recv_byte(output logic [7:0] b, input int stall);
      bit acc = 0;
      repeat (stall) @(negedge clk);
      out_ready = 1;
      while (!acc) begin
         acc = out_valid;
         b   = out_data;
         @(negedge clk);
      end
      out_ready = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   function automatic int clampv(int v);
      return (v < MIN_NS) ? MIN_NS : (v > MAX_NS) ? MAX_NS : v;
   endfunction

   task automatic tck_case(input int v, input int stall);
      logic [7:0] b;
      int got = 0;
      send_str("settck:");
      send_u32(v);
      for (int i = 0; i < 4; i++) begin
         recv_byte(b, stall);
         got = got | (int'(b) << (8 * i));
      end
      check(got == clampv(v), "R3 settck reply", got, clampv(v));
      check(int'(tck_div) == clampv(v) / (2 * CLK_NS), "R4 divider", tck_div, clampv(v) / (2 * CLK_NS));
   endtask

   task automatic shift_case(input int n);
      int nb = (n + 7) / 8;
      int bad = 0;
      logic [7:0] b, tms, tdi, mask;
      int cnt;
      log_n = 0;
      send_str("shift:");
      send_u32(n);
      for (int k = 0; k < nb; k++) send_byte(8'(n * 37 + k * 11 + 5));
      for (int k = 0; k < 2 * nb - 1; k++) if (k < nb) ; // TMS done, TDI next
      for (int k = 0; k < nb; k++) begin
         if (k == nb - 1) check(log_n == 0, "R5 no request before last TDI byte", log_n, 0);
         send_byte(8'((n * 53) ^ (k * 29)) + 8'd1);
      end
      for (int k = 0; k < nb; k++) begin
         recv_byte(b, k % 3);
         tdi  = 8'((n * 53) ^ (k * 29)) + 8'd1;
         cnt  = (k == nb - 1 && n % 8 != 0) ? n % 8 : 8;
         mask = 8'hFF >> (8 - cnt);
         check(b == (~tdi & mask), "R7 TDO byte", b, ~tdi & mask);
      end
      check(log_n == nb, "R6 request count", log_n, nb);
      for (int k = 0; k < nb && k < log_n; k++) begin
         tms = 8'(n * 37 + k * 11 + 5);
         tdi = 8'((n * 53) ^ (k * 29)) + 8'd1;
         cnt = (k == nb - 1 && n % 8 != 0) ? n % 8 : 8;
         if (log_tms[k] != tms || log_tdi[k] != tdi || int'(log_cnt[k]) != cnt) begin
            bad++;
            $display("FAIL R6 n=%0d byte %0d actual=%0h/%0h/%0d expected=%0h/%0h/%0d",
                     n, k, log_tms[k], log_tdi[k], log_cnt[k], tms, tdi, cnt);
         end
      end
      n_cmp++;
      if (bad != 0) n_bad++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      string info;
      logic [7:0] b;
      @(negedge clk);
      do_reset();
      // R11 reset state
      check(in_ready == 1, "R11 in_ready", in_ready, 1);
      check(out_valid == 0 && sh_req == 0 && err == 0, "R11 idle outputs",
            {out_valid, sh_req, err}, 0);
      check(int'(tck_div) == DEF_NS / (2 * CLK_NS), "R4 reset divider", tck_div, DEF_NS / (2 * CLK_NS));

      // R2 version string, R9 serialisation
      info = $sformatf("xvcServer_v1.0:%0d\n", MAXB);
      send_str("getinfo:");
      check(in_ready == 0, "R9 input blocked during reply", in_ready, 0);
      for (int i = 0; i < info.len(); i++) begin
         recv_byte(b, i % 2);
         check(b == info[i], "R2 info byte", b, info[i]);
      end
      check(in_ready == 1, "R9 input reopened after reply", in_ready, 1);

      // R3/R4 clamp sweep with backpressure
      tck_case(100, 0);
      tck_case(5, 2);
      tck_case(50000, 1);
      tck_case(MIN_NS, 0);
      tck_case(MAX_NS, 3);
      tck_case(333, 1);
      tck_case(MIN_NS - 1, 0);
      tck_case(MAX_NS + 1, 0);

      // R5 zero-length shift: no request, no reply
      log_n = 0;
      send_str("shift:");
      send_u32(0);
      repeat (6) @(negedge clk);
      check(out_valid == 0 && log_n == 0, "R5 zero count silent", {out_valid, log_n[0]}, 0);
      check(in_ready == 1, "R5 ready after zero count", in_ready, 1);

      // R5/R6/R7 every bit count
      for (int n = 1; n <= MAXB; n++) shift_case(n);

      // R8 oversized count
      send_str("shift:");
      send_u32(MAXB + 1);
      check(err == 1, "R8 err on oversized count", err, 1);
      send_str("getinfo:");
      repeat (4) @(negedge clk);
      check(out_valid == 0 && err == 1 && in_ready == 1, "R8 input discarded",
            {out_valid, err, in_ready}, 3'b011);
      do_reset();
      check(err == 0, "R11 reset clears err", err, 0);

      // R1 unknown prefixes
      send_str("gex");
      check(err == 1, "R1 bad third char", err, 1);
      send_str("settck:");
      send_u32(200);
      repeat (4) @(negedge clk);
      check(out_valid == 0 && int'(tck_div) == DEF_NS / (2 * CLK_NS), "R1 settck ignored in error",
            tck_div, DEF_NS / (2 * CLK_NS));
      do_reset();
      send_str("shifX");
      check(err == 1, "R1 bad shift prefix", err, 1);
      do_reset();
      send_str("q");
      check(err == 1, "R1 bad first char", err, 1);
      do_reset();
      tck_case(400, 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule